// File: doc/BRIEF.md
# Hardware Thread Enable Manager

This block sits beside one multithreaded core with sixteen hardware threads that share a single execution unit. Software reaches it through a small register port. One register holds the per-thread enable mask and a field that records the log2 of the active thread count. A second register turns on the whole multithreading machinery, the time-slice scheduler and the stall-driven switch, and sets the two 8-bit limits those use.

A thread is brought up in two steps. Software first writes an init command that names the thread. It then watches a status word that shows busy, error and the id of the thread being worked on. Once the init completes, software ORs the thread's bit into the enable mask. Thread 0 is the boot thread and is turned on by writing a mask of 1.

While multithreading is on, a round-robin scheduler keeps exactly one enabled thread active. It moves to the next enabled thread in ascending circular order when the time slice runs out, when the running thread has stalled for long enough, or when the running thread loses its enable bit. The register port is a plain single-cycle write strobe with a combinational read. No data stream passes through the block, so it has no valid/ready interface and no back-pressure.

Top module: `thread_enable_mgr`

## Requirements
- R1: After reset, every register reads 0 and `thread_active` is 0.
- R2: The configuration word (address 0) keeps the enable mask in bits 31:16 and the active-count field in bits 15:13. The control word (address 3) keeps the master enable in bit 0, the slice enable in bit 1, the stall enable in bit 2, the slice limit in bits 15:8 and the stall limit in bits 23:16. All other bits of both words read 0.
- R3: While the master enable is 1, `thread_active` is one-hot on the current thread if that thread's mask bit is set, and 0 otherwise. The first thread after the master enable turns on is thread 0.
- R4: A write to address 1 with bit 0 set and a thread id in bits 31:28, naming a thread whose mask bit is clear, starts an init. From the next cycle the status word (address 2) shows busy at bit 0, error at bit 1 clear and the id in bits 31:28. Busy stays high for INIT_CYCLES cycles and then clears, while the id remains.
- R5: An init command written while busy is high is ignored. The id does not change and busy clears at the original time.
- R6: An init command for a thread whose mask bit is already set leaves busy low, sets error and echoes the id. A later accepted command clears error.
- R7: With the slice enable on and slice limit L, each thread stays active for L+1 cycles. The scheduler then moves to the next enabled thread in ascending circular order and skips threads whose bit is clear.
- R8: With the stall enable on and stall limit S, a thread that sees `exec_stall` high for S+1 consecutive cycles gives way to the next enabled thread.
- R9: If no switch condition holds, the current thread does not change. When only thread 0 is enabled, thread 0 stays active.
- R10: If the mask bit of the running thread is cleared, `thread_active` reads 0 for that cycle and the next enabled thread takes over at the following edge.
- R11: Clearing the master enable drives `thread_active` to 0 and returns the scheduler to thread 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register address (0 config, 1 init command, 2 init status, 3 control) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| exec_stall | input | 1 | The running thread is stalled this cycle |
| thread_active | output | 16 | One-hot grant of the execution unit |

## Verification
A wrong scheduler pointer or slice counter shows on `thread_active` in the very next cycle. The grant changes one cycle early or late, or lands on a disabled thread. For that reason the bench compares the grant against a cycle-by-cycle expected sequence. A fault in the init sequencer shows in the status word. The busy window comes out the wrong length, or an ignored command replaces the echoed id, and the bench sees this by polling the status on every cycle of the window.

// File: rtl/twm_pkg.sv
package twm_pkg;
  localparam int DATA_W = 32;
  localparam int NAT_W  = 3;

  typedef enum logic [1:0] {
    A_CFG  = 2'd0,
    A_INIT = 2'd1,
    A_STAT = 2'd2,
    A_CTRL = 2'd3
  } twm_addr_e;

  localparam int CFG_MASK_LSB   = 16;
  localparam int CFG_NAT_LSB    = 13;
  localparam int CMD_START_BIT  = 0;
  localparam int CMD_ID_LSB     = 28;
  localparam int STAT_BUSY_BIT  = 0;
  localparam int STAT_ERR_BIT   = 1;
  localparam int CTRL_MT_BIT    = 0;
  localparam int CTRL_SLICE_BIT = 1;
  localparam int CTRL_STALL_BIT = 2;
  localparam int CTRL_SLIM_LSB  = 8;
  localparam int CTRL_TLIM_LSB  = 16;
endpackage

// File: rtl/twm_regs.sv
module twm_regs
  import twm_pkg::*;
#(
  parameter int NT = 16,
  parameter int CW = 8,
  parameter int TW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              st_busy,
  input  logic              st_err,
  input  logic [TW-1:0]     st_id,
  output logic [NT-1:0]     mask,
  output logic              mt_en,
  output logic              slice_en,
  output logic              stall_en,
  output logic [CW-1:0]     slice_lim,
  output logic [CW-1:0]     stall_lim,
  output logic              cmd_valid,
  output logic [TW-1:0]     cmd_id,
  output logic [DATA_W-1:0] rdata
);
  logic [NAT_W-1:0] nat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask      <= '0;
      nat       <= '0;
      mt_en     <= 1'b0;
      slice_en  <= 1'b0;
      stall_en  <= 1'b0;
      slice_lim <= '0;
      stall_lim <= '0;
    end else if (wr) begin
      if (addr == A_CFG) begin
        mask <= wdata[CFG_MASK_LSB +: NT];
        nat  <= wdata[CFG_NAT_LSB +: NAT_W];
      end
      if (addr == A_CTRL) begin
        mt_en     <= wdata[CTRL_MT_BIT];
        slice_en  <= wdata[CTRL_SLICE_BIT];
        stall_en  <= wdata[CTRL_STALL_BIT];
        slice_lim <= wdata[CTRL_SLIM_LSB +: CW];
        stall_lim <= wdata[CTRL_TLIM_LSB +: CW];
      end
    end
  end

  assign cmd_valid = wr && (addr == A_INIT) && wdata[CMD_START_BIT];
  assign cmd_id    = wdata[CMD_ID_LSB +: TW];

  always_comb begin
    rdata = '0;
    case (addr)
      A_CFG: begin
        rdata[CFG_MASK_LSB +: NT]   = mask;
        rdata[CFG_NAT_LSB +: NAT_W] = nat;
      end
      A_STAT: begin
        rdata[STAT_BUSY_BIT]      = st_busy;
        rdata[STAT_ERR_BIT]       = st_err;
        rdata[CMD_ID_LSB +: TW]   = st_id;
      end
      A_CTRL: begin
        rdata[CTRL_MT_BIT]          = mt_en;
        rdata[CTRL_SLICE_BIT]       = slice_en;
        rdata[CTRL_STALL_BIT]       = stall_en;
        rdata[CTRL_SLIM_LSB +: CW]  = slice_lim;
        rdata[CTRL_TLIM_LSB +: CW]  = stall_lim;
      end
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/twm_init.sv
module twm_init #(
  parameter int NT          = 16,
  parameter int TW          = 4,
  parameter int INIT_CYCLES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [TW-1:0] cmd_id,
  input  logic [NT-1:0] mask,
  output logic          busy,
  output logic          err,
  output logic [TW-1:0] id
);
  localparam int IC_W = $clog2(INIT_CYCLES + 1);
  localparam logic [IC_W-1:0] LOAD = IC_W'(INIT_CYCLES - 1);

  logic [IC_W-1:0] remain;

  // A command is taken only when idle; a thread that is already enabled
  // is refused at once with the error flag.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      err    <= 1'b0;
      id     <= '0;
      remain <= '0;
    end else if (cmd_valid && !busy) begin
      id <= cmd_id;
      if (mask[cmd_id]) begin
        err  <= 1'b1;
        busy <= 1'b0;
      end else begin
        err    <= 1'b0;
        busy   <= 1'b1;
        remain <= LOAD;
      end
    end else if (busy) begin
      if (remain == '0) busy <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/twm_sched.sv
module twm_sched #(
  parameter int NT = 16,
  parameter int CW = 8,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mt_en,
  input  logic          slice_en,
  input  logic          stall_en,
  input  logic [CW-1:0] slice_lim,
  input  logic [CW-1:0] stall_lim,
  input  logic [NT-1:0] mask,
  input  logic          stall,
  output logic [TW-1:0] cur,
  output logic [NT-1:0] active
);
  logic [TW-1:0] nxt;
  logic [TW-1:0] cand;
  logic          found;
  logic [CW-1:0] slot;
  logic [CW-1:0] run;
  logic          slice_hit;
  logic          stall_hit;
  logic          lost_en;
  logic          switch_now;

  // Rotating search: first enabled thread after cur, wrapping to cur itself;
  // thread 0 when the mask is empty.
  always_comb begin
    nxt   = '0;
    cand  = '0;
    found = 1'b0;
    for (int i = 1; i <= NT; i++) begin
      cand = TW'((int'(cur) + i) % NT);
      if (!found && mask[cand]) begin
        nxt   = cand;
        found = 1'b1;
      end
    end
  end

  assign slice_hit  = slice_en && (slot == slice_lim);
  assign stall_hit  = stall_en && stall && (run == stall_lim);
  assign lost_en    = !mask[cur];
  assign switch_now = slice_hit || stall_hit || lost_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur  <= '0;
      slot <= '0;
      run  <= '0;
    end else if (!mt_en) begin
      cur  <= '0;
      slot <= '0;
      run  <= '0;
    end else if (switch_now) begin
      cur  <= nxt;
      slot <= '0;
      run  <= '0;
    end else begin
      slot <= slot + 1'b1;
      run  <= stall ? run + 1'b1 : '0;
    end
  end

  for (genvar g = 0; g < NT; g++) begin : g_grant
    assign active[g] = mt_en && mask[g] && (cur == TW'(g));
  end
endmodule

// File: rtl/thread_enable_mgr.sv
module thread_enable_mgr
  import twm_pkg::*;
#(
  parameter int NUM_THREADS = 16,
  parameter int CNT_W       = 8,
  parameter int INIT_CYCLES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic [1:0]             reg_addr,
  input  logic [DATA_W-1:0]      reg_wdata,
  output logic [DATA_W-1:0]      reg_rdata,
  input  logic                   exec_stall,
  output logic [NUM_THREADS-1:0] thread_active
);
  localparam int TW = $clog2(NUM_THREADS);

  logic [NUM_THREADS-1:0] cfg_mask;
  logic                   mt_en;
  logic                   slice_en;
  logic                   stall_en;
  logic [CNT_W-1:0]       slice_lim;
  logic [CNT_W-1:0]       stall_lim;
  logic                   cmd_valid;
  logic [TW-1:0]          cmd_id;
  logic                   init_busy;
  logic                   init_err;
  logic [TW-1:0]          init_id;
  logic [TW-1:0]          cur_thread;

  twm_regs #(.NT(NUM_THREADS), .CW(CNT_W), .TW(TW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .st_busy(init_busy), .st_err(init_err), .st_id(init_id),
    .mask(cfg_mask), .mt_en(mt_en), .slice_en(slice_en), .stall_en(stall_en),
    .slice_lim(slice_lim), .stall_lim(stall_lim),
    .cmd_valid(cmd_valid), .cmd_id(cmd_id), .rdata(reg_rdata)
  );

  twm_init #(.NT(NUM_THREADS), .TW(TW), .INIT_CYCLES(INIT_CYCLES)) u_init (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_id(cmd_id),
    .mask(cfg_mask), .busy(init_busy), .err(init_err), .id(init_id)
  );

  twm_sched #(.NT(NUM_THREADS), .CW(CNT_W), .TW(TW)) u_sched (
    .clk(clk), .rst_n(rst_n), .mt_en(mt_en), .slice_en(slice_en),
    .stall_en(stall_en), .slice_lim(slice_lim), .stall_lim(stall_lim),
    .mask(cfg_mask), .stall(exec_stall), .cur(cur_thread),
    .active(thread_active)
  );
endmodule

// File: rtl/twm_chk.sv
module twm_chk #(
  parameter int NT = 16,
  parameter int TW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [1:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic [NT-1:0] cfg_mask,
  input logic          mt_en,
  input logic          slice_en,
  input logic          stall_en,
  input logic          init_busy,
  input logic          init_err,
  input logic [TW-1:0] init_id,
  input logic [TW-1:0] cur_thread,
  input logic [NT-1:0] thread_active
);
  // R3
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(thread_active));

  // R3
  grant_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thread_active & ~cfg_mask) == '0);

  // R5
  busy_ignores_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_busy && reg_wr && reg_addr == 2'd1 && reg_wdata[0])
    |=> (init_id == $past(init_id)));

  // R6
  enabled_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_busy && reg_wr && reg_addr == 2'd1 && reg_wdata[0] &&
     cfg_mask[reg_wdata[31:28]])
    |=> (init_err && !init_busy));

  // R9
  only_zero_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mask == NT'(1)) |=> (cur_thread == '0));

  // R9
  no_cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mt_en && !slice_en && !stall_en && cfg_mask[cur_thread])
    |=> $stable(cur_thread));
endmodule

bind thread_enable_mgr twm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .cfg_mask(cfg_mask), .mt_en(mt_en),
  .slice_en(slice_en), .stall_en(stall_en), .init_busy(init_busy),
  .init_err(init_err), .init_id(init_id), .cur_thread(cur_thread),
  .thread_active(thread_active)
);

// File: tb/test_thread_enable_mgr.sv
module test_thread_enable_mgr;
  localparam int INIT_CYC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        exec_stall = 1'b0;
  logic [15:0] thread_active;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0] exp_val[$];
  string       exp_tag[$];

  always #10 clk = ~clk;

  thread_enable_mgr #(.INIT_CYCLES(INIT_CYC)) i_thread_enable_mgr (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .exec_stall(exec_stall),
    .thread_active(thread_active)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_exp(input logic [15:0] v, input string t);
    exp_val.push_back(v);
    exp_tag.push_back(t);
  endtask

  // Monitor: compares the grant a quarter period after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_val.size() > 0) begin
        logic [15:0] e;
        string t;
        e = exp_val.pop_front();
        t = exp_tag.pop_front();
        chk(t, {16'h0, thread_active}, {16'h0, e});
      end
    end
  end

  task automatic wr_begin(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_addr = a;
    reg_wdata = d;
  endtask

  task automatic wr_end();
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_begin(a, d);
    wr_end();
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic drain();
    while (exp_val.size() > 0) @(negedge clk);
  endtask

  function automatic int next_en(input int cur, input logic [15:0] m);
    for (int i = 1; i <= 16; i++) begin
      if (m[(cur + i) % 16]) return (cur + i) % 16;
    end
    return 0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int cur;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 reg", d, 32'h0);
    end
    chk("R1 active", {16'h0, thread_active}, 32'h0);

    // R2 field placement; R11 master off keeps grant at 0
    wr(2'd0, 32'h000B_A001);
    rd(2'd0, d);
    chk("R2 cfg", d, 32'h000B_A000);
    wr(2'd3, 32'h8003_0506);
    rd(2'd3, d);
    chk("R2 ctrl", d, 32'h0003_0506);
    chk("R11 off", {16'h0, thread_active}, 32'h0);

    // R3 + R7: slice limit 2, mask {0,1,3}
    wr_begin(2'd3, 32'h0000_0203);
    cur = 0;
    for (int k = 0; k < 5; k++) begin
      for (int r = 0; r < 3; r++) push_exp(16'(1 << cur), "R7 slice");
      cur = next_en(cur, 16'h000B);
    end
    wr_end();
    drain();

    // R9 no switch cause: master only
    wr(2'd3, 32'h0);
    wr_begin(2'd3, 32'h0000_0001);
    for (int k = 0; k < 6; k++) push_exp(16'h0001, "R9 hold");
    wr_end();
    drain();

    // R10 running thread loses its bit
    wr_begin(2'd0, 32'h000A_0000);
    push_exp(16'h0000, "R10 gap");
    for (int k = 0; k < 5; k++) push_exp(16'h0002, "R10 next");
    wr_end();
    drain();

    // R9 only thread 0 enabled, slicing on
    wr(2'd3, 32'h0);
    wr(2'd0, 32'h0001_0000);
    wr_begin(2'd3, 32'h0000_0203);
    for (int k = 0; k < 8; k++) push_exp(16'h0001, "R9 only0");
    wr_end();
    drain();

    // R11 master off
    wr_begin(2'd3, 32'h0);
    for (int k = 0; k < 3; k++) push_exp(16'h0000, "R11 off");
    wr_end();
    drain();

    // R8 stall switch, limit 1
    wr(2'd0, 32'h000B_0000);
    wr_begin(2'd3, 32'h0001_0005);
    exec_stall = 1'b1;
    cur = 0;
    for (int k = 0; k < 4; k++) begin
      for (int r = 0; r < 2; r++) push_exp(16'(1 << cur), "R8 stall");
      cur = next_en(cur, 16'h000B);
    end
    wr_end();
    drain();
    wr(2'd3, 32'h0);
    exec_stall = 1'b0;

    // R4 + R5: init thread 5, repeat command for 6 while busy
    wr(2'd1, 32'h5000_0001);
    reg_wr = 1'b1;
    reg_addr = 2'd1;
    reg_wdata = 32'h6000_0001;
    @(negedge clk);
    reg_wr = 1'b0;
    n = 0;
    rd(2'd2, d);
    while (d[0] && n < 40) begin
      chk("R5 id kept", d, 32'h5000_0001);
      n++;
      @(negedge clk);
      rd(2'd2, d);
    end
    chk("R4 busy length", 32'(n), 32'(INIT_CYC - 1));
    chk("R4 done", d, 32'h5000_0000);

    // R6 refused for enabled thread 1, then cleared by accepted command
    wr(2'd1, 32'h1000_0001);
    rd(2'd2, d);
    chk("R6 err", d, 32'h1000_0002);
    wr(2'd1, 32'h2000_0001);
    rd(2'd2, d);
    chk("R6 err cleared", d, 32'h2000_0001);
    repeat (INIT_CYC + 2) @(negedge clk);
    rd(2'd2, d);
    chk("R4 idle", d, 32'h2000_0000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule